// File: doc/BRIEF.md
# Clock Frequency Monitor with Self-Test Fault Injection

This block checks whether a monitored clock runs at its expected rate. Both the monitored clock and a reference clock arrive as plain inputs. A fast system clock samples them through synchronizers, and the block detects their rising edges. The reference clock drives a window generator: a counter that toggles an internal window signal once every programmed number of reference rising edges. While a window is open, monitored-clock edges pass through a selectable prescaler and are accumulated. At the end of each window the total is captured. The capture is then compared with a low limit and a high limit, and sticky under-frequency and over-frequency flags are set when it falls outside them.

A small register file configures the block. It holds a control word, the window period, the two limits, the read-only capture and a write-one-to-clear status word. For self-test, the control word can inject a fault without touching the real clocks. It can halve the monitored edge stream, halve the reference edge stream, or blank the monitored clock entirely. A correctly working monitor must then flag the fault. A global enable and two power-state qualifiers decide when the monitor is active:

- stop-in-idle with an idle input
- run-in-sleep with a sleep input

While the monitor is inactive, counting, window progress and flagging are all frozen.

Top module: `fmon_top`

## Requirements
- R1: CTRL bit 0 is the enable and resets to 1. While it is 0, the window counter, the accumulator and the flags do not advance, so no capture occurs and no flag is set.
- R2: CTRL bit 1 is stop-in-idle and resets to 0. When it is 1 and `idle_i` is high, the monitor is inactive as in R1. When it is 0, `idle_i` has no effect.
- R3: CTRL bit 2 is run-in-sleep and resets to 0. When it is 0 and `sleep_i` is high, the monitor is inactive. When it is 1, the monitor keeps working during sleep.
- R4: CTRL bits 4:3 select the monitored-edge prescaler: 00 = /1, 01 = /2, 10 = /4, and the reserved 11 = /1.
- R5: CTRL bits 6:5 select the injected fault: 00 = none, 01 = pass every second monitored edge, 10 = pass every second reference edge, 11 = pass no monitored edges.
- R6: CTRL bit 7 selects the window. With 0, a window runs from one rise of the window signal to the next, so one window lasts 2*PERIOD reference edges. With 1, a window runs from a rise to the following fall, so it lasts PERIOD reference edges.
- R7: The window signal toggles after every PERIOD active reference rising edges (register address 1, 32 bits, reset 0). PERIOD = 0 stops the window signal, and no window ever ends.
- R8: At every window end, the prescaled count of that window is written into CAPTURE (address 4, read-only, reset 0, also on `cap_count_o`). The accumulator then restarts from 0. Writes to address 4 are ignored.
- R9: A capture below LOW (address 2, reset 0) sets the under flag, STATUS bit 0. A capture above HIGH (address 3, reset all ones) sets the over flag, STATUS bit 1. Each flag stays set until a write to STATUS (address 5) with a 1 in its bit position. A set in the same cycle wins over the clear.
- R10: CTRL resets to 0x01 and keeps only bits 7:0. Unused bits of every register, and the unmapped addresses 6 and 7, read as 0. STATUS bits above bit 1 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_clk_i | input | 1 | Monitored clock, sampled |
| ref_clk_i | input | 1 | Reference clock, sampled |
| idle_i | input | 1 | Idle power state indication |
| sleep_i | input | 1 | Sleep power state indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| cap_count_o | output | CNT_W | Last captured window count |
| over_o | output | 1 | Sticky over-frequency flag |
| under_o | output | 1 | Sticky under-frequency flag |

## Verification
The embedded assertions check, on every cycle, the rules that can be seen locally:

- an inactive monitor leaves its accumulator untouched and ends no window
- a mode-1 window always closes on a fall of the window signal
- the blanking fault lets no monitored edge through
- the limit comparisons set the flags, and the flags stay set until cleared

Only the bench scenarios can show the resulting counts: the exact totals for every combination of prescaler, fault and window mode; the freezing caused by each power qualifier; that PERIOD = 0 produces no window; and the register reset values, reserved bits and selective flag clearing.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

   typedef struct packed {
      logic       win_mode;
      logic [1:0] fault;
      logic [1:0] div;
      logic       sleep_run;
      logic       stop_idle;
      logic       enable;
   } ctrl_t;

   localparam logic [2:0] A_CTRL   = 3'd0;
   localparam logic [2:0] A_PERIOD = 3'd1;
   localparam logic [2:0] A_LOW    = 3'd2;
   localparam logic [2:0] A_HIGH   = 3'd3;
   localparam logic [2:0] A_CAPT   = 3'd4;
   localparam logic [2:0] A_STAT   = 3'd5;

   localparam logic [1:0] FI_NONE  = 2'b00;
   localparam logic [1:0] FI_MON_H = 2'b01;
   localparam logic [1:0] FI_REF_H = 2'b10;
   localparam logic [1:0] FI_BLANK = 2'b11;

   localparam logic [1:0] DV_1 = 2'b00;
   localparam logic [1:0] DV_2 = 2'b01;
   localparam logic [1:0] DV_4 = 2'b10;

   localparam int CTRL_W = $bits(ctrl_t);
   localparam ctrl_t CTRL_RST = ctrl_t'(8'h01);

endpackage

// File: rtl/fmon_edge.sv
module fmon_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fmon_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/fmon_window.sv
module fmon_window #(
   parameter int PER_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             ref_pulse,
   input  logic [PER_W-1:0] period,
   input  logic             win_mode,
   output logic             gen_q,
   output logic             win_start,
   output logic             win_end
);
   generate
      if (PER_W < 2) begin : g_bad_per
         $error("fmon_window: PER_W must be at least 2");
      end
   endgenerate

   logic [PER_W-1:0] cnt_q;
   logic             per_on;
   logic             toggle;

   assign per_on = (period != '0);
   assign toggle = active & ref_pulse & per_on & (cnt_q >= period - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n || !per_on) begin
         cnt_q <= '0;
         gen_q <= 1'b0;
      end else if (active && ref_pulse) begin
         if (toggle) begin
            cnt_q <= '0;
            gen_q <= ~gen_q;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign win_start = toggle & ~gen_q;
   assign win_end   = win_mode ? (toggle & gen_q) : (toggle & ~gen_q);

   AST_NO_WIN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !win_end);                                     // R1
   AST_MODE1_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && win_mode) |=> !gen_q);                         // R6
   AST_NO_PERIOD_NO_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      (period == '0) |=> !gen_q);                                // R7

endmodule

// File: rtl/fmon_accum.sv
module fmon_accum #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             mon_pulse,
   input  logic [1:0]       div_sel,
   input  logic             win_mode,
   input  logic             gen_q,
   input  logic             win_start,
   input  logic             win_end,
   output logic [CNT_W-1:0] cap_q,
   output logic             cap_stb
);
   import fmon_pkg::*;

   logic [1:0]       pre_q;
   logic [1:0]       pre_lim;
   logic             tick;
   logic             count_en;
   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] acc_inc;
   logic [CNT_W-1:0] cap_next;

   always_comb begin
      unique case (div_sel)
         DV_2:    pre_lim = 2'd1;
         DV_4:    pre_lim = 2'd3;
         default: pre_lim = 2'd0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pre_q <= '0;
      else if (active && mon_pulse) pre_q <= (pre_q >= pre_lim) ? 2'd0 : pre_q + 2'd1;
   end

   assign tick     = active & mon_pulse & (pre_q >= pre_lim);
   assign count_en = tick & (gen_q | ~win_mode);

   generate
      if (SATURATE) begin : g_sat
         assign acc_inc = (&acc_q) ? acc_q : acc_q + 1'b1;
      end else begin : g_wrap
         assign acc_inc = acc_q + 1'b1;
      end
   endgenerate

   assign cap_next = count_en ? acc_inc : acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         cap_q   <= '0;
         cap_stb <= 1'b0;
      end else begin
         cap_stb <= win_end;
         if (win_end) begin
            cap_q <= cap_next;
            acc_q <= '0;
         end else if (win_start) begin
            acc_q <= '0;
         end else if (count_en) begin
            acc_q <= acc_inc;
         end
      end
   end

   AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> $stable(acc_q));                               // R1
   AST_CAP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(cap_q));                              // R8

endmodule

// File: rtl/fmon_top.sv
module fmon_top #(
   parameter int DATA_W   = 32,
   parameter int PER_W    = 32,
   parameter int CNT_W    = 16,
   parameter int STAGES   = 2,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_clk_i,
   input  logic              ref_clk_i,
   input  logic              idle_i,
   input  logic              sleep_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [2:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [CNT_W-1:0]  cap_count_o,
   output logic              over_o,
   output logic              under_o
);
   import fmon_pkg::*;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("fmon_top: CNT_W must lie in 2..DATA_W");
      end
      if (PER_W > DATA_W || DATA_W < CTRL_W) begin : g_bad_data
         $error("fmon_top: DATA_W too narrow");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [PER_W-1:0] period_q;
   logic [CNT_W-1:0] low_q;
   logic [CNT_W-1:0] high_q;
   logic             over_q;
   logic             under_q;
   logic             active;
   logic             mon_rise;
   logic             ref_rise;
   logic             mon_ph_q;
   logic             ref_ph_q;
   logic             mon_pulse;
   logic             ref_pulse;
   logic             gen_q;
   logic             win_start;
   logic             win_end;
   logic [CNT_W-1:0] cap_q;
   logic             cap_stb;
   logic             clr_under;
   logic             clr_over;
   logic             unused_bits;

   assign unused_bits = ^wr_data_i;

   // register file
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_RST;
         period_q <= '0;
         low_q    <= '0;
         high_q   <= '1;
      end else if (wr_en_i) begin
         unique case (wr_addr_i)
            A_CTRL:   ctrl_q   <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
            A_PERIOD: period_q <= wr_data_i[PER_W-1:0];
            A_LOW:    low_q    <= wr_data_i[CNT_W-1:0];
            A_HIGH:   high_q   <= wr_data_i[CNT_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      rd_data_o = '0;
      unique case (rd_addr_i)
         A_CTRL:   rd_data_o[CTRL_W-1:0] = ctrl_q;
         A_PERIOD: rd_data_o[PER_W-1:0]  = period_q;
         A_LOW:    rd_data_o[CNT_W-1:0]  = low_q;
         A_HIGH:   rd_data_o[CNT_W-1:0]  = high_q;
         A_CAPT:   rd_data_o[CNT_W-1:0]  = cap_q;
         A_STAT:   rd_data_o[1:0]        = {over_q, under_q};
         default:  rd_data_o = '0;
      endcase
   end

   // power qualification
   assign active = ctrl_q.enable
                 & ~(ctrl_q.stop_idle & idle_i)
                 & ~(sleep_i & ~ctrl_q.sleep_run);

   // edge detection
   fmon_edge #(.STAGES(STAGES)) u_mon_edge (
      .clk(clk), .rst_n(rst_n), .din(mon_clk_i), .rise(mon_rise));
   fmon_edge #(.STAGES(STAGES)) u_ref_edge (
      .clk(clk), .rst_n(rst_n), .din(ref_clk_i), .rise(ref_rise));

   // fault injection
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mon_ph_q <= 1'b0;
         ref_ph_q <= 1'b0;
      end else begin
         if (active && mon_rise) mon_ph_q <= ~mon_ph_q;
         if (active && ref_rise) ref_ph_q <= ~ref_ph_q;
      end
   end

   always_comb begin
      mon_pulse = mon_rise;
      ref_pulse = ref_rise;
      unique case (ctrl_q.fault)
         FI_MON_H: mon_pulse = mon_rise & mon_ph_q;
         FI_REF_H: ref_pulse = ref_rise & ref_ph_q;
         FI_BLANK: mon_pulse = 1'b0;
         default:  ;
      endcase
   end

   fmon_window #(.PER_W(PER_W)) u_window (
      .clk(clk), .rst_n(rst_n), .active(active), .ref_pulse(ref_pulse),
      .period(period_q), .win_mode(ctrl_q.win_mode), .gen_q(gen_q),
      .win_start(win_start), .win_end(win_end));

   fmon_accum #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_accum (
      .clk(clk), .rst_n(rst_n), .active(active), .mon_pulse(mon_pulse),
      .div_sel(ctrl_q.div), .win_mode(ctrl_q.win_mode), .gen_q(gen_q),
      .win_start(win_start), .win_end(win_end), .cap_q(cap_q),
      .cap_stb(cap_stb));

   // sticky limit flags
   assign clr_under = wr_en_i & (wr_addr_i == A_STAT) & wr_data_i[0];
   assign clr_over  = wr_en_i & (wr_addr_i == A_STAT) & wr_data_i[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         under_q <= 1'b0;
         over_q  <= 1'b0;
      end else begin
         if (cap_stb && (cap_q < low_q))  under_q <= 1'b1;
         else if (clr_under)              under_q <= 1'b0;
         if (cap_stb && (cap_q > high_q)) over_q  <= 1'b1;
         else if (clr_over)               over_q  <= 1'b0;
      end
   end

   assign cap_count_o = cap_q;
   assign over_o      = over_q;
   assign under_o     = under_q;

   AST_OVER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_stb && (cap_q > high_q)) |=> over_q);                 // R9
   AST_UNDER_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_stb && (cap_q < low_q)) |=> under_q);                 // R9
   AST_OVER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (over_q && !clr_over) |=> over_q);                         // R9
   AST_BLANK_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.fault == FI_BLANK) |-> !mon_pulse);                // R5
   AST_CTRL_RESET: assert property (@(posedge clk)
      !rst_n |=> (ctrl_q == CTRL_RST));                          // R10

endmodule

// File: tb/tb_fmon_top.sv
module tb_fmon_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_clk_i = 1'b0;
   logic        ref_clk_i = 1'b0;
   logic        idle_i = 1'b0;
   logic        sleep_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [2:0]  wr_addr_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [2:0]  rd_addr_i = '0;
   logic [31:0] rd_data_o;
   logic [15:0] cap_count_o;
   logic        over_o;
   logic        under_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   fmon_top dut (
      .clk(clk), .rst_n(rst_n), .mon_clk_i(mon_clk_i), .ref_clk_i(ref_clk_i),
      .idle_i(idle_i), .sleep_i(sleep_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o), .cap_count_o(cap_count_o), .over_o(over_o),
      .under_o(under_o));

   always #2.5 clk = ~clk;

   // monitored clock: period 4 system cycles, reference: period 20
   initial forever begin repeat (2)  @(negedge clk); mon_clk_i = ~mon_clk_i; end
   initial forever begin repeat (10) @(negedge clk); ref_clk_i = ~ref_clk_i; end

   // {div[14:13], fault[12:11], mode[10], expected count[9:0]} with PERIOD = 8
   localparam logic [15:0] VEC [12] = '{
      {1'b0, 2'd0, 2'd0, 1'b0, 10'd80},
      {1'b0, 2'd1, 2'd0, 1'b0, 10'd40},
      {1'b0, 2'd2, 2'd0, 1'b0, 10'd20},
      {1'b0, 2'd3, 2'd0, 1'b0, 10'd80},
      {1'b0, 2'd0, 2'd0, 1'b1, 10'd40},
      {1'b0, 2'd1, 2'd0, 1'b1, 10'd20},
      {1'b0, 2'd2, 2'd0, 1'b1, 10'd10},
      {1'b0, 2'd0, 2'd1, 1'b0, 10'd40},
      {1'b0, 2'd0, 2'd2, 1'b0, 10'd160},
      {1'b0, 2'd0, 2'd3, 1'b0, 10'd0},
      {1'b0, 2'd0, 2'd1, 1'b1, 10'd20},
      {1'b0, 2'd0, 2'd2, 1'b1, 10'd80}
   };
   localparam int LOW_LIM  = 25;
   localparam int HIGH_LIM = 70;

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr_i = a;
      #1 d = rd_data_o;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // power-state case: flags after clear, with limits forcing over for 80
   task automatic power_case(input string req, input logic [7:0] c,
                             input logic idl, input logic slp, input logic [31:0] exp);
      logic [31:0] v;
      wr(3'd0, {24'd0, c});
      idle_i = idl; sleep_i = slp;
      wait_cyc(300);
      wr(3'd5, 32'h3);
      wait_cyc(1500);
      rd(3'd5, v);
      chk(req, v, exp);
      idle_i = 1'b0; sleep_i = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] held;
      wait_cyc(4);
      rst_n = 1'b1;

      // reset state (R10, R1, R7, R8, R9)
      rd(3'd0, v); chk("R10 ctrl reset", v, 32'h01);
      rd(3'd1, v); chk("R7 period reset", v, 32'h0);
      rd(3'd2, v); chk("R9 low reset", v, 32'h0);
      rd(3'd3, v); chk("R9 high reset", v, 32'h0000FFFF);
      rd(3'd4, v); chk("R8 capture reset", v, 32'h0);
      rd(3'd5, v); chk("R9 status reset", v, 32'h0);

      wr(3'd1, 32'd8);
      wr(3'd2, LOW_LIM);
      wr(3'd3, HIGH_LIM);

      // table walk: R4 prescaler, R5 faults, R6 window mode, R8 capture, R9 flags
      foreach (VEC[i]) begin
         logic [9:0] e;
         logic [31:0] st;
         e = VEC[i][9:0];
         wr(3'd0, {24'd0, VEC[i][10], VEC[i][12:11], VEC[i][14:13], 3'b001});
         wait_cyc(1500);
         wr(3'd5, 32'h3);
         wait_cyc(700);
         rd(3'd4, v);
         chk($sformatf("R4/R5/R6/R8 vector %0d count", i), v, {22'd0, e});
         chk($sformatf("R8 vector %0d port", i), {16'd0, cap_count_o}, {22'd0, e});
         st = {30'd0, (e > HIGH_LIM), (e < LOW_LIM)};
         rd(3'd5, v);
         chk($sformatf("R9 vector %0d flags", i), v, st);
      end

      // power qualifiers, plain count 80 is over the high limit
      power_case("R1 enable off", 8'h00, 1'b0, 1'b0, 32'h0);
      power_case("R1 enable on", 8'h01, 1'b0, 1'b0, 32'h2);
      power_case("R2 idle stop", 8'h03, 1'b1, 1'b0, 32'h0);
      power_case("R2 idle ignored", 8'h01, 1'b1, 1'b0, 32'h2);
      power_case("R3 sleep stop", 8'h01, 1'b0, 1'b1, 32'h0);
      power_case("R3 sleep run", 8'h05, 1'b0, 1'b1, 32'h2);

      // selective write-one-to-clear (R9)
      wr(3'd2, 32'd100);
      wr(3'd3, 32'd50);
      wr(3'd0, 32'h01);
      wait_cyc(1500);
      rd(3'd5, v); chk("R9 both flags", v, 32'h3);
      chk("R9 flag ports", {30'd0, over_o, under_o}, 32'h3);
      wr(3'd0, 32'h00);
      wait_cyc(50);
      wr(3'd5, 32'hFFFF_FFFC);
      rd(3'd5, v); chk("R10 status upper bits ignored", v, 32'h3);
      wr(3'd5, 32'h1);
      rd(3'd5, v); chk("R9 clear under only", v, 32'h2);
      wr(3'd5, 32'h2);
      rd(3'd5, v); chk("R9 clear over", v, 32'h0);

      // capture is read-only (R8)
      rd(3'd4, held);
      wr(3'd4, 32'h1234);
      rd(3'd4, v); chk("R8 capture write ignored", v, held);

      // period zero: no window ends, no flags (R7)
      wr(3'd1, 32'd0);
      wr(3'd0, 32'h01);
      wait_cyc(1500);
      rd(3'd5, v); chk("R7 period zero no flags", v, 32'h0);
      rd(3'd4, v); chk("R7 period zero capture held", v, held);
      wr(3'd1, 32'd8);
      wait_cyc(1500);
      rd(3'd5, v); chk("R7 period restored", v, 32'h3);

      // reserved bits (R10)
      wr(3'd0, 32'hFFFF_FF81);
      rd(3'd0, v); chk("R10 ctrl reserved bits", v, 32'h81);
      rd(3'd6, v); chk("R10 unmapped address", v, 32'h0);
      wr(3'd2, 32'hABCD_0011);
      rd(3'd2, v); chk("R10 low upper bits", v, 32'h0000_0011);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule